// File: doc/BRIEF.md
# Protection Entry Configuration Register File

This block stores the settings that a memory-protection checker consumes: one 8-bit configuration byte and one address word for each protection entry, plus a small security-control register. Software writes the configuration bytes through a packed 32-bit port, four entries per word. It writes address words one entry at a time. The block decides, for each byte or word offered, whether the write may land. That decision uses per-entry lock bits, a locked top-of-range successor, a lock-bypass bit and two sticky lockdown bits.

All stored values are presented flat on outputs for the range decoder and access checker. Those sit outside this block. A single-cycle `changed_o` pulse tells them that some stored value actually moved, so cached decisions can be dropped. Reads are combinational from the stored state. Writes on all three ports may occur in the same cycle, and each is judged against the state held before that edge.

Top module: `pmp_cfgfile`

## Requirements
- R1: A configuration byte uses bit 0 = read, bit 1 = write, bit 2 = execute, bits 4:3 = match mode (value 1 = top-of-range), and bit 7 = lock. Entry e appears at `ent_cfg_o[8e+7:8e]` and at byte e mod 4 of configuration read word e/4.
- R2: A configuration write to word k offers byte i to entry 4k+i, and each byte is accepted or refused on its own. Bytes for entries at or beyond the entry count are discarded.
- R3: With bypass and lockdown both clear, a configuration byte for an entry whose lock bit is set is refused. Other bytes of the same word are still written.
- R4: While the bypass bit is 1, no entry counts as locked, for both configuration and address writes.
- R5: An address write to an entry that counts as locked is refused.
- R6: An address write to entry i is refused when entry i+1 has lock set and match mode 1, even while bypass is 1. A locked successor in any other mode does not block it.
- R7: The security register holds lockdown at bit 0, default-deny at bit 1 and bypass at bit 2. A security write forces bypass to 0 when bypass is currently 0 and any entry has its lock bit set.
- R8: Once lockdown or default-deny is 1, a later security write cannot clear it.
- R9: `changed_o` is 1 for exactly the cycle after a clock edge at which some stored value changed. A write that leaves every value as it was does not raise it.
- R10: After reset every configuration byte, address word and security bit reads 0, and `changed_o` is 0.
- R11: Reading an address index or configuration word with no backing entry returns 0. Writing one changes nothing.
- R12: While lockdown is 1 and bypass is 0, a configuration byte is accepted only when it has lock=1 and execute=0, or when it has lock=0 and its low three bits are not 3'b110. This holds whether or not the entry is currently locked.
- R13: A write offered in a cycle is visible on the read ports and flat outputs in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration word write strobe |
| cfg_widx | input | 3 | Configuration word write index |
| cfg_wdata | input | 32 | Four packed configuration bytes |
| cfg_ridx | input | 3 | Configuration word read index |
| cfg_rdata | output | 32 | Packed configuration read data |
| adr_we | input | 1 | Address write strobe |
| adr_widx | input | 5 | Address write entry index |
| adr_wdata | input | 32 | Address write data |
| adr_ridx | input | 5 | Address read entry index |
| adr_rdata | output | 32 | Address read data |
| sec_we | input | 1 | Security register write strobe |
| sec_wdata | input | 3 | Security write data {bypass, default-deny, lockdown} |
| sec_rdata | output | 3 | Security register value |
| ent_cfg_o | output | 128 | All configuration bytes, entry 0 in the low byte |
| ent_addr_o | output | 512 | All address words, entry 0 in the low word |
| changed_o | output | 1 | One-cycle pulse after any stored value changed |

## Verification
Every stored value is registered exactly once. A write driven in one cycle therefore shows on the combinational read ports after the next rising edge. `changed_o` rises after that same edge and is gone one edge later. The bench drives each write at a falling edge. At the following falling edge it samples `changed_o` and then releases the strobe, so the pulse is caught in its only valid cycle. It reads the register ports after that edge, with a small delay added so the read index has settled. To confirm that the pulse lasts a single cycle, it samples once more one cycle later.

// File: rtl/pmpcfg_pkg.sv
package pmpcfg_pkg;

  localparam int CFG_BYTE_W     = 8;
  localparam int BYTES_PER_WORD = 4;
  localparam int CFG_WORD_W     = CFG_BYTE_W * BYTES_PER_WORD;

  localparam logic [1:0] MODE_TOR = 2'd1;
  localparam logic [2:0] WX_ONLY  = 3'b110;

  typedef struct packed {
    logic       lock;
    logic [1:0] rsvd;
    logic [1:0] mode;
    logic       x;
    logic       w;
    logic       r;
  } ent_cfg_t;

  typedef struct packed {
    logic bypass;
    logic deny_dflt;
    logic lockdown;
  } sec_t;

  // entry is protected against rewrite (bypass overrides every lock)
  function automatic logic ent_locked(ent_cfg_t c, sec_t s);
    return c.lock && !s.bypass;
  endfunction

  // acceptance rule for a single configuration byte
  function automatic logic cfg_accept(ent_cfg_t cur, ent_cfg_t nw, sec_t s);
    logic ok;
    ok = 1'b0;
    if (s.bypass) begin
      ok = 1'b1;
    end else if (!s.lockdown) begin
      ok = !cur.lock;
    end else begin
      if (nw.lock && !nw.x) ok = 1'b1;
      if (!nw.lock && ({nw.x, nw.w, nw.r} != WX_ONLY)) ok = 1'b1;
    end
    return ok;
  endfunction

  // successor entry forbids rewriting the base address of its range
  function automatic logic tor_guard(ent_cfg_t nxt);
    return nxt.lock && (nxt.mode == MODE_TOR);
  endfunction

  // next value of the security register on a write
  function automatic sec_t sec_next(sec_t cur, sec_t wr, logic any_lock);
    sec_t n;
    n = wr;
    if (!cur.bypass && any_lock) n.bypass = 1'b0;
    n.lockdown  = wr.lockdown  | cur.lockdown;
    n.deny_dflt = wr.deny_dflt | cur.deny_dflt;
    return n;
  endfunction

endpackage

// File: rtl/pmp_cfg_bank.sv
module pmp_cfg_bank
  import pmpcfg_pkg::*;
#(
  parameter int N_ENT = 16,
  parameter int CW_IW = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      we,
  input  logic [CW_IW-1:0]          widx,
  input  logic [CFG_WORD_W-1:0]     wdata,
  input  logic [CW_IW-1:0]          ridx,
  input  sec_t                      sec,
  output logic [CFG_WORD_W-1:0]     rdata,
  output ent_cfg_t [N_ENT-1:0]      cfg_q,
  output logic                      any_lock,
  output logic                      changed
);

  ent_cfg_t [N_ENT-1:0] nxt_cfg;
  logic     [N_ENT-1:0] commit;
  logic     [N_ENT-1:0] lock_bits;

  for (genvar i = 0; i < N_ENT; i++) begin : g_ent
    localparam int WORD = i / BYTES_PER_WORD;
    localparam int LANE = i % BYTES_PER_WORD;

    logic     hit;
    logic     ok;
    ent_cfg_t offered;

    assign offered      = ent_cfg_t'(wdata[LANE*CFG_BYTE_W +: CFG_BYTE_W]);
    assign hit          = we && (widx == CW_IW'(WORD));
    assign ok           = cfg_accept(cfg_q[i], offered, sec);
    assign nxt_cfg[i]   = offered;
    assign commit[i]    = hit && ok && (offered != cfg_q[i]);
    assign lock_bits[i] = cfg_q[i].lock;

    // R3: a locked entry keeps its byte while no bypass or lockdown applies
    p_lock_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_q[i].lock && !sec.bypass && !sec.lockdown) |=> $stable(cfg_q[i]));

    // R12: under lockdown an unlocked write-plus-execute byte never lands
    p_lockdown_wx_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && sec.lockdown && !sec.bypass && !offered.lock &&
       ({offered.x, offered.w, offered.r} == WX_ONLY)) |=> $stable(cfg_q[i]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else begin
      for (int j = 0; j < N_ENT; j++) begin
        if (commit[j]) cfg_q[j] <= nxt_cfg[j];
      end
    end
  end

  always_comb begin
    rdata = '0;
    for (int j = 0; j < N_ENT; j++) begin
      if (ridx == CW_IW'(j / BYTES_PER_WORD))
        rdata[(j % BYTES_PER_WORD)*CFG_BYTE_W +: CFG_BYTE_W] = cfg_q[j];
    end
  end

  assign any_lock = |lock_bits;
  assign changed  = |commit;

  // R9: no write strobe means no change recorded
  p_cfg_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(cfg_q));

endmodule

// File: rtl/pmp_addr_bank.sv
module pmp_addr_bank
  import pmpcfg_pkg::*;
#(
  parameter int N_ENT  = 16,
  parameter int ADDR_W = 32,
  parameter int EN_IW  = 5
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          we,
  input  logic [EN_IW-1:0]              widx,
  input  logic [ADDR_W-1:0]             wdata,
  input  logic [EN_IW-1:0]              ridx,
  input  ent_cfg_t [N_ENT-1:0]          cfg,
  input  sec_t                          sec,
  output logic [ADDR_W-1:0]             rdata,
  output logic [N_ENT-1:0][ADDR_W-1:0]  addr_q,
  output logic                          changed
);

  logic [N_ENT-1:0] commit;

  for (genvar i = 0; i < N_ENT; i++) begin : g_ent
    logic hit;
    logic guard;
    logic ok;

    if (i + 1 < N_ENT) begin : g_succ
      assign guard = tor_guard(cfg[i+1]);

      // R6: a locked top-of-range successor freezes this base address
      p_tor_guard_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg[i+1].lock && (cfg[i+1].mode == MODE_TOR)) |=> $stable(addr_q[i]));
    end else begin : g_last
      assign guard = 1'b0;
    end

    assign hit       = we && (widx == EN_IW'(i));
    assign ok        = !guard && !ent_locked(cfg[i], sec);
    assign commit[i] = hit && ok && (wdata != addr_q[i]);

    // R5: the address of a locked entry stays put
    p_self_lock_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg[i].lock && !sec.bypass) |=> $stable(addr_q[i]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else begin
      for (int j = 0; j < N_ENT; j++) begin
        if (commit[j]) addr_q[j] <= wdata;
      end
    end
  end

  always_comb begin
    rdata = '0;
    for (int j = 0; j < N_ENT; j++) begin
      if (ridx == EN_IW'(j)) rdata = addr_q[j];
    end
  end

  assign changed = |commit;

endmodule

// File: rtl/pmp_sec_reg.sv
module pmp_sec_reg
  import pmpcfg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic we,
  input  sec_t wdata,
  input  logic any_lock,
  output sec_t sec_q,
  output logic changed
);

  sec_t nxt;

  assign nxt     = sec_next(sec_q, wdata, any_lock);
  assign changed = we && (nxt != sec_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sec_q <= '0;
    else if (changed) sec_q <= nxt;
  end

  // R8: lockdown and default-deny never fall once set
  p_lockdown_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sec_q.lockdown |=> sec_q.lockdown);
  p_deny_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sec_q.deny_dflt |=> sec_q.deny_dflt);

  // R7: bypass cannot be raised while some entry is locked
  p_bypass_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!sec_q.bypass && any_lock) |=> !sec_q.bypass);

endmodule

// File: rtl/pmp_cfgfile.sv
module pmp_cfgfile
  import pmpcfg_pkg::*;
#(
  parameter int N_ENT  = 16,
  parameter int ADDR_W = 32,
  localparam int CFG_WORDS = (N_ENT + BYTES_PER_WORD - 1) / BYTES_PER_WORD,
  localparam int CW_IW     = $clog2(CFG_WORDS) + 1,
  localparam int EN_IW     = $clog2(N_ENT) + 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_we,
  input  logic [CW_IW-1:0]          cfg_widx,
  input  logic [CFG_WORD_W-1:0]     cfg_wdata,
  input  logic [CW_IW-1:0]          cfg_ridx,
  output logic [CFG_WORD_W-1:0]     cfg_rdata,
  input  logic                      adr_we,
  input  logic [EN_IW-1:0]          adr_widx,
  input  logic [ADDR_W-1:0]         adr_wdata,
  input  logic [EN_IW-1:0]          adr_ridx,
  output logic [ADDR_W-1:0]         adr_rdata,
  input  logic                      sec_we,
  input  logic [2:0]                sec_wdata,
  output logic [2:0]                sec_rdata,
  output logic [N_ENT*8-1:0]        ent_cfg_o,
  output logic [N_ENT*ADDR_W-1:0]   ent_addr_o,
  output logic                      changed_o
);

  ent_cfg_t [N_ENT-1:0]             cfg_q;
  logic     [N_ENT-1:0][ADDR_W-1:0] addr_q;
  sec_t                             sec_q;
  logic                             any_lock;
  logic                             cfg_chg;
  logic                             adr_chg;
  logic                             sec_chg;

  pmp_cfg_bank #(.N_ENT(N_ENT), .CW_IW(CW_IW)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (cfg_we),
    .widx     (cfg_widx),
    .wdata    (cfg_wdata),
    .ridx     (cfg_ridx),
    .sec      (sec_q),
    .rdata    (cfg_rdata),
    .cfg_q    (cfg_q),
    .any_lock (any_lock),
    .changed  (cfg_chg)
  );

  pmp_addr_bank #(.N_ENT(N_ENT), .ADDR_W(ADDR_W), .EN_IW(EN_IW)) u_addr (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (adr_we),
    .widx    (adr_widx),
    .wdata   (adr_wdata),
    .ridx    (adr_ridx),
    .cfg     (cfg_q),
    .sec     (sec_q),
    .rdata   (adr_rdata),
    .addr_q  (addr_q),
    .changed (adr_chg)
  );

  pmp_sec_reg u_sec (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (sec_we),
    .wdata    (sec_t'(sec_wdata)),
    .any_lock (any_lock),
    .sec_q    (sec_q),
    .changed  (sec_chg)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) changed_o <= 1'b0;
    else        changed_o <= cfg_chg | adr_chg | sec_chg;
  end

  assign sec_rdata  = sec_q;
  assign ent_cfg_o  = cfg_q;
  assign ent_addr_o = addr_q;

  // R9: with every strobe idle the change pulse stays low next cycle
  p_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_we && !adr_we && !sec_we) |=> !changed_o);

  // R9: the pulse never lasts two cycles without a fresh strobe
  p_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (changed_o && !cfg_we && !adr_we && !sec_we) |=> !changed_o);

endmodule

// File: tb/pmp_cfgfile_tb_top.sv
module pmp_cfgfile_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_widx = '0;
  logic [31:0] cfg_wdata = '0;
  logic [2:0]  cfg_ridx = '0;
  logic [31:0] cfg_rdata;
  logic        adr_we = 1'b0;
  logic [4:0]  adr_widx = '0;
  logic [31:0] adr_wdata = '0;
  logic [4:0]  adr_ridx = '0;
  logic [31:0] adr_rdata;
  logic        sec_we = 1'b0;
  logic [2:0]  sec_wdata = '0;
  logic [2:0]  sec_rdata;
  logic [127:0] ent_cfg_o;
  logic [511:0] ent_addr_o;
  logic        changed_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pmp_cfgfile dut_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_widx(cfg_widx), .cfg_wdata(cfg_wdata),
    .cfg_ridx(cfg_ridx), .cfg_rdata(cfg_rdata),
    .adr_we(adr_we), .adr_widx(adr_widx), .adr_wdata(adr_wdata),
    .adr_ridx(adr_ridx), .adr_rdata(adr_rdata),
    .sec_we(sec_we), .sec_wdata(sec_wdata), .sec_rdata(sec_rdata),
    .ent_cfg_o(ent_cfg_o), .ent_addr_o(ent_addr_o), .changed_o(changed_o)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr_cfg(input logic [2:0] k, input logic [31:0] d, output logic ch);
    @(negedge clk); cfg_we = 1'b1; cfg_widx = k; cfg_wdata = d;
    @(negedge clk); ch = changed_o; cfg_we = 1'b0;
  endtask

  task automatic wr_adr(input logic [4:0] k, input logic [31:0] d, output logic ch);
    @(negedge clk); adr_we = 1'b1; adr_widx = k; adr_wdata = d;
    @(negedge clk); ch = changed_o; adr_we = 1'b0;
  endtask

  task automatic wr_sec(input logic [2:0] d, output logic ch);
    @(negedge clk); sec_we = 1'b1; sec_wdata = d;
    @(negedge clk); ch = changed_o; sec_we = 1'b0;
  endtask

  task automatic rd_cfg(input logic [2:0] k, output logic [31:0] v);
    cfg_ridx = k; #1; v = cfg_rdata;
  endtask

  task automatic rd_adr(input logic [4:0] k, output logic [31:0] v);
    adr_ridx = k; #1; v = adr_rdata;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    do_reset();
    for (int k = 0; k < 4; k++) begin
      rd_cfg(3'(k), v); check("R10 cfg word after reset", v, 32'h0);
    end
    rd_adr(5'd0, v);  check("R10 addr after reset", v, 32'h0);
    check("R10 sec after reset", {29'h0, sec_rdata}, 32'h0);
    check("R10 changed after reset", {31'h0, changed_o}, 32'h0);
    check("R10 flat cfg after reset", {31'h0, |ent_cfg_o}, 32'h0);
  endtask

  task automatic t_packed();
    logic ch; logic [31:0] v;
    wr_cfg(3'd1, 32'h1F0B0301, ch);
    check("R9 pulse on real change", {31'h0, ch}, 32'h1);
    rd_cfg(3'd1, v); check("R2 R13 word1 readback", v, 32'h1F0B0301);
    check("R1 entry5 on flat output", {24'h0, ent_cfg_o[47:40]}, 32'h03);
    @(negedge clk);
    check("R9 pulse lasts one cycle", {31'h0, changed_o}, 32'h0);
    wr_cfg(3'd1, 32'h1F0B0301, ch);
    check("R9 no pulse on same value", {31'h0, ch}, 32'h0);
  endtask

  task automatic t_range();
    logic ch; logic [31:0] v;
    wr_cfg(3'd5, 32'hFFFFFFFF, ch);
    check("R11 out-of-range cfg write no change", {31'h0, ch}, 32'h0);
    rd_cfg(3'd5, v); check("R11 out-of-range cfg read", v, 32'h0);
    rd_cfg(3'd1, v); check("R11 word1 untouched", v, 32'h1F0B0301);
    wr_adr(5'd20, 32'hDEAD, ch);
    check("R11 out-of-range addr write no change", {31'h0, ch}, 32'h0);
    rd_adr(5'd20, v); check("R11 out-of-range addr read", v, 32'h0);
    wr_adr(5'd3, 32'h1234, ch);
    check("R13 addr write pulse", {31'h0, ch}, 32'h1);
    rd_adr(5'd3, v); check("R13 addr3 readback", v, 32'h1234);
    wr_adr(5'd3, 32'h1234, ch);
    check("R9 same addr no pulse", {31'h0, ch}, 32'h0);
  endtask

  task automatic t_lock();
    logic ch; logic [31:0] v;
    wr_cfg(3'd0, 32'h00000083, ch);
    wr_cfg(3'd0, 32'h00000500, ch);
    rd_cfg(3'd0, v); check("R3 locked byte kept, neighbour written", v, 32'h00000583);
    wr_adr(5'd0, 32'hBEEF, ch);
    rd_adr(5'd0, v); check("R5 locked entry address refused", v, 32'h0);
  endtask

  task automatic t_tor();
    logic ch; logic [31:0] v;
    wr_cfg(3'd0, 32'h00880583, ch);
    rd_cfg(3'd0, v); check("R6 entry2 locked TOR set", v, 32'h00880583);
    wr_adr(5'd1, 32'hABCD, ch);
    rd_adr(5'd1, v); check("R6 addr1 blocked by locked TOR successor", v, 32'h0);
    wr_cfg(3'd1, 32'h1F900301, ch);
    rd_cfg(3'd1, v); check("R6 entry6 locked non-TOR", v, 32'h1F900301);
    wr_adr(5'd5, 32'h55, ch);
    rd_adr(5'd5, v); check("R6 non-TOR locked successor does not block", v, 32'h55);
  endtask

  task automatic t_rlb_blocked();
    logic ch;
    wr_sec(3'b100, ch);
    check("R7 bypass refused while locked", {29'h0, sec_rdata}, 32'h0);
    check("R7 no pulse on refused bypass", {31'h0, ch}, 32'h0);
  endtask

  task automatic t_bypass();
    logic ch; logic [31:0] v;
    do_reset();
    wr_sec(3'b100, ch);
    check("R7 bypass accepted with no locks", {29'h0, sec_rdata}, 32'h4);
    wr_cfg(3'd0, 32'h00008883, ch);
    wr_cfg(3'd0, 32'h00008801, ch);
    rd_cfg(3'd0, v); check("R4 locked byte rewritten under bypass", v, 32'h00008801);
    wr_adr(5'd1, 32'h77, ch);
    rd_adr(5'd1, v); check("R4 locked address rewritten under bypass", v, 32'h77);
    wr_adr(5'd0, 32'h66, ch);
    rd_adr(5'd0, v); check("R6 TOR successor blocks even under bypass", v, 32'h0);
    wr_sec(3'b000, ch);
    check("R7 bypass cleared", {29'h0, sec_rdata}, 32'h0);
    wr_sec(3'b100, ch);
    check("R7 bypass refused after clear", {29'h0, sec_rdata}, 32'h0);
  endtask

  task automatic t_sticky();
    logic ch;
    do_reset();
    wr_sec(3'b011, ch);
    check("R8 lockdown and deny set", {29'h0, sec_rdata}, 32'h3);
    wr_sec(3'b000, ch);
    check("R8 sticky bits survive clear", {29'h0, sec_rdata}, 32'h3);
    check("R9 no pulse on sticky clear", {31'h0, ch}, 32'h0);
  endtask

  task automatic t_lockdown();
    logic ch; logic [31:0] v;
    wr_cfg(3'd0, 32'h07068185, ch);
    rd_cfg(3'd0, v); check("R12 lockdown acceptance per byte", v, 32'h07008100);
    wr_cfg(3'd0, 32'h00000100, ch);
    rd_cfg(3'd0, v); check("R12 locked entry accepts allowed byte", v, 32'h00000100);
  endtask

  initial begin
    t_reset();
    t_packed();
    t_range();
    t_lock();
    t_tor();
    t_rlb_blocked();
    t_bypass();
    t_sticky();
    t_lockdown();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule